// File: doc/BRIEF.md
# Synchronous BCD Digit Transfer Sequencer

This block paces the fixed-rate digit bursts that move a number between an arithmetic unit's X register and the outside world. There is no handshake. After a start-input or start-output command, the block walks through the X-register digit positions, one timed slot per digit. In each slot it drives an active-low strobe and a 4-bit position address. An input burst samples an incoming BCD digit and hands it to the register file with its position. An output burst reads the digit at the current address and presents it on the data pins, together with a one-microcycle read/write pulse.

All timing counts in microcycles of four clocks. Input slots last 10 microcycles. Output slots last 14, which leaves a slow host more time per digit. The number of slots depends on a programmable mantissa digit count (1 to 8) and on the notation mode latched at start. A select line stays low for the whole burst, so a host can detect the end without counting digits. A one-clock done pulse also marks the end.

Top module: `bcd_xfer_seq`

## Requirements
- R1: After reset, isel and strobe_n are 1, rw_n is 1, and dig_addr, dout, wr_en, wr_data, wr_pos and done are 0. The mantissa digit count is 8.
- R2: A pulse on mdc_load with mdc_val in 1..8 sets the digit count. A value of 0 or above 8 is ignored, and so is a load while a burst is running.
- R3: With sci_mode=1 at start, the burst visits positions 0 up to count+3 (count+4 slots). With sci_mode=0 it visits positions 2 up to count+3 (count+2 slots). Positions rise by one per slot.
- R4: In an input burst, strobe_n goes low for exactly 4 clocks per slot, and successive falling edges are 40 clocks apart.
- R5: In an input burst, wr_en is high for one clock, 4 clocks after each strobe_n rising edge. In that clock, wr_data carries din and wr_pos equals dig_addr. wr_en never rises in an output burst.
- R6: In an output burst, strobe_n goes low for exactly 4 clocks per slot, and successive falling edges are 56 clocks apart.
- R7: In an output burst, dout takes x_rdata for the current dig_addr in the clock in which strobe_n rises. Outside an output burst, dout is 0.
- R8: In an output burst, rw_n gives exactly one low pulse of 4 clocks per slot, starting 4 clocks after strobe_n rises. In an input burst, rw_n stays 1.
- R9: During a burst, dig_addr shows the position of the current slot. Outside a burst, dig_addr is 0.
- R10: isel falls together with the first strobe_n fall, two clocks after start is sampled, and stays low until the last slot ends. done is high for exactly one clock, which is the last clock of isel low.
- R11: A start during a burst is ignored, and start_in together with start_out starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_in | input | 1 | Begin an input burst (one-clock pulse) |
| start_out | input | 1 | Begin an output burst (one-clock pulse) |
| sci_mode | input | 1 | 1 = scientific layout, 0 = floating-point layout; latched at start |
| mdc_load | input | 1 | Load a new mantissa digit count |
| mdc_val | input | 4 | Digit count to load (1..8 valid) |
| din | input | 4 | Incoming BCD digit |
| x_rdata | input | 4 | X-register digit at position dig_addr |
| strobe_n | output | 1 | Active-low digit strobe, one microcycle per slot |
| dig_addr | output | 4 | Current digit position, 0 when idle |
| isel | output | 1 | Low for the whole burst |
| wr_en | output | 1 | Sampled digit valid (one clock) |
| wr_pos | output | 4 | Position of the sampled digit |
| wr_data | output | 4 | Sampled digit |
| dout | output | 4 | Outgoing BCD digit |
| rw_n | output | 1 | Active-low digit-valid pulse during output |
| done | output | 1 | One-clock end-of-burst pulse |

## Verification
The bench builds the block with its default parameters: four clocks per microcycle, slot lengths of 10 and 14 microcycles, and an upper digit count of 8. With these values the extremes of the position range are within reach. A count of 1 in floating-point layout gives the shortest burst of three slots, and a count of 8 in scientific layout reaches position 11 across twelve slots. Both slot lengths are measured clock by clock on strobe edges. Illegal counts, loads and starts during a burst, and a simultaneous start on both lines are each followed by a burst whose length shows that the stimulus had no effect.

// File: rtl/bcd_xfer_pkg.sv
package bcd_xfer_pkg;
  typedef enum logic [1:0] {
    XF_IDLE = 2'd0,
    XF_IN   = 2'd1,
    XF_OUT  = 2'd2
  } xf_mode_e;

  // first position and slots beyond the digit count, per layout
  localparam int SCI_FIRST = 0;
  localparam int FLT_FIRST = 2;
  localparam int SCI_EXTRA = 4;
  localparam int FLT_EXTRA = 2;
endpackage

// File: rtl/xfer_mdc_reg.sv
module xfer_mdc_reg #(
  parameter int MDC_MAX = 8,
  parameter int MDC_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [MDC_W-1:0] val,
  input  logic             lock,
  output logic [MDC_W-1:0] mdc
);
  localparam logic [MDC_W-1:0] MAX_V = MDC_W'(MDC_MAX);

  logic legal;
  assign legal = (val != '0) && (val <= MAX_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc <= MAX_V;
    end else if (load && !lock && legal) begin
      mdc <= val;
    end
  end

  // R2
  mdc_range_chk: assert property (@(posedge clk) disable iff (rst)
    (mdc != '0) && (mdc <= MAX_V));

  // R2
  mdc_lock_chk: assert property (@(posedge clk) disable iff (rst)
    lock |=> $stable(mdc));
endmodule

// File: rtl/xfer_mc_timer.sv
module xfer_mc_timer #(
  parameter int PH_BITS    = 2,
  parameter int IN_PERIOD  = 10,
  parameter int OUT_PERIOD = 14,
  parameter int MC_W       = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               out_sel,
  output logic [PH_BITS-1:0] ph,
  output logic [MC_W-1:0]    mc,
  output logic               slot_end
);
  localparam logic [PH_BITS-1:0] PH_LAST = '1;

  logic [MC_W-1:0] mc_last;
  assign mc_last  = out_sel ? MC_W'(OUT_PERIOD - 1) : MC_W'(IN_PERIOD - 1);
  assign slot_end = run && (ph == PH_LAST) && (mc == mc_last);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      ph <= '0;
      mc <= '0;
    end else begin
      ph <= ph + 1'b1;
      if (ph == PH_LAST) begin
        mc <= (mc == mc_last) ? '0 : mc + 1'b1;
      end
    end
  end

  // R4 R6
  mc_bound_chk: assert property (@(posedge clk) disable iff (rst)
    mc <= mc_last);

  // R4 R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (ph == '0) || run);
endmodule

// File: rtl/xfer_slot_ctr.sv
module xfer_slot_ctr #(
  parameter int AW      = 4,
  parameter int POS_MAX = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] first,
  input  logic [AW-1:0] total,
  input  logic          advance,
  output logic [AW-1:0] pos,
  output logic          last
);
  logic [AW-1:0] left;

  assign last = (left == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos  <= '0;
      left <= '0;
    end else if (load) begin
      pos  <= first;
      left <= total - 1'b1;
    end else if (advance && !last) begin
      pos  <= pos + 1'b1;
      left <= left - 1'b1;
    end
  end

  // R3
  pos_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pos <= AW'(POS_MAX));

  // R3
  pos_step_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && !last && !load) |=> pos == $past(pos) + 1'b1);
endmodule

// File: rtl/bcd_xfer_seq.sv
module bcd_xfer_seq
  import bcd_xfer_pkg::*;
#(
  parameter int PH_BITS    = 2,
  parameter int IN_PERIOD  = 10,
  parameter int OUT_PERIOD = 14,
  parameter int MDC_MAX    = 8,
  parameter int MDC_W      = 4,
  parameter int AW         = 4,
  parameter int DW         = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_in,
  input  logic             start_out,
  input  logic             sci_mode,
  input  logic             mdc_load,
  input  logic [MDC_W-1:0] mdc_val,
  input  logic [DW-1:0]    din,
  input  logic [DW-1:0]    x_rdata,
  output logic             strobe_n,
  output logic [AW-1:0]    dig_addr,
  output logic             isel,
  output logic             wr_en,
  output logic [AW-1:0]    wr_pos,
  output logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    dout,
  output logic             rw_n,
  output logic             done
);
  localparam int MAXP    = (OUT_PERIOD > IN_PERIOD) ? OUT_PERIOD : IN_PERIOD;
  localparam int MC_W    = $clog2(MAXP);
  localparam int POS_MAX = MDC_MAX + SCI_EXTRA - 1;
  localparam logic [PH_BITS-1:0] PH_ZERO = '0;

  xf_mode_e mode_q;
  logic [MDC_W-1:0]   mdc;
  logic [PH_BITS-1:0] ph;
  logic [MC_W-1:0]    mc;
  logic               slot_end, last, run, accept, end_burst;
  logic [AW-1:0]      pos, first, total;

  assign run       = (mode_q != XF_IDLE);
  assign accept    = !run && (start_in ^ start_out);
  assign end_burst = slot_end && last;
  assign first     = sci_mode ? AW'(SCI_FIRST) : AW'(FLT_FIRST);
  assign total     = AW'(mdc) + (sci_mode ? AW'(SCI_EXTRA) : AW'(FLT_EXTRA));

  xfer_mdc_reg #(.MDC_MAX(MDC_MAX), .MDC_W(MDC_W)) u_mdc (
    .clk(clk), .rst(rst), .load(mdc_load), .val(mdc_val),
    .lock(run), .mdc(mdc)
  );

  xfer_mc_timer #(.PH_BITS(PH_BITS), .IN_PERIOD(IN_PERIOD),
                  .OUT_PERIOD(OUT_PERIOD), .MC_W(MC_W)) u_timer (
    .clk(clk), .rst(rst), .run(run), .out_sel(mode_q == XF_OUT),
    .ph(ph), .mc(mc), .slot_end(slot_end)
  );

  xfer_slot_ctr #(.AW(AW), .POS_MAX(POS_MAX)) u_slots (
    .clk(clk), .rst(rst), .load(accept), .first(first), .total(total),
    .advance(slot_end), .pos(pos), .last(last)
  );

  // burst mode
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= XF_IDLE;
    end else if (accept) begin
      mode_q <= start_out ? XF_OUT : XF_IN;
    end else if (end_burst) begin
      mode_q <= XF_IDLE;
    end
  end

  // registered pins, one clock behind the counter state
  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_n <= 1'b1;
      isel     <= 1'b1;
      dig_addr <= '0;
      wr_en    <= 1'b0;
      wr_pos   <= '0;
      wr_data  <= '0;
      dout     <= '0;
      rw_n     <= 1'b1;
      done     <= 1'b0;
    end else begin
      strobe_n <= !(run && mc == '0);
      isel     <= !run;
      dig_addr <= run ? pos : '0;
      done     <= end_burst;
      if (mode_q == XF_IN && mc == MC_W'(2) && ph == PH_ZERO) begin
        wr_en   <= 1'b1;
        wr_pos  <= pos;
        wr_data <= din;
      end else begin
        wr_en   <= 1'b0;
        wr_pos  <= '0;
        wr_data <= '0;
      end
      if (mode_q != XF_OUT) begin
        dout <= '0;
      end else if (mc == MC_W'(1) && ph == PH_ZERO) begin
        dout <= x_rdata;
      end
      rw_n <= !(mode_q == XF_OUT && mc == MC_W'(2));
    end
  end

  // R9
  addr_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    isel |-> dig_addr == '0);

  // R10
  done_then_isel_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> isel);

  // R4
  strobe_framed_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe_n |-> !isel);

  // R8
  rw_output_only_chk: assert property (@(posedge clk) disable iff (rst)
    !rw_n |-> mode_q == XF_OUT);

  // R5
  wr_single_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !end_burst) |=> mode_q == $past(mode_q));

  // R7
  dout_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (isel && !done) |-> dout == '0);
endmodule

// File: tb/bcd_xfer_seq_tb.sv
module bcd_xfer_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_in = 1'b0, start_out = 1'b0, sci_mode = 1'b1, mdc_load = 1'b0;
  logic [3:0] mdc_val = 4'd0;
  logic [3:0] din, x_rdata;
  logic strobe_n, isel, wr_en, rw_n, done;
  logic [3:0] dig_addr, wr_pos, wr_data, dout;
  int seed = 0;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  function automatic logic [3:0] dval(input logic [3:0] p, input int s);
    return 4'((int'(p) * 3 + s) % 10);
  endfunction
  function automatic logic [3:0] xval(input logic [3:0] p, input int s);
    return 4'((int'(p) * 7 + s + 1) % 10);
  endfunction

  assign din     = dval(dig_addr, seed);
  assign x_rdata = xval(dig_addr, seed);

  bcd_xfer_seq u_dut (
    .clk(clk), .rst(rst), .start_in(start_in), .start_out(start_out),
    .sci_mode(sci_mode), .mdc_load(mdc_load), .mdc_val(mdc_val),
    .din(din), .x_rdata(x_rdata), .strobe_n(strobe_n), .dig_addr(dig_addr),
    .isel(isel), .wr_en(wr_en), .wr_pos(wr_pos), .wr_data(wr_data),
    .dout(dout), .rw_n(rw_n), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic load_mdc(input int v);
    @(negedge clk); mdc_load = 1'b1; mdc_val = 4'(v);
    @(negedge clk); mdc_load = 1'b0;
  endtask

  // one burst, measured clock by clock; poke drives loads and starts mid-burst
  task automatic run_burst(input bit out_m, input bit sci, input int mdc, input bit poke);
    int first = sci ? 0 : 2;
    int slots = sci ? mdc + 4 : mdc + 2;
    int period = out_m ? 56 : 40;
    int t = 0, n_fall = 0, last_fall = -1, low_len = 0, rise_t = -100, rw_len = 0;
    int bad_per = 0, bad_wid = 0, bad_addr = 0, bad_wr = 0, bad_rw = 0, bad_dout = 0;
    int n_wr = 0, n_rw = 0, n_done = 0, done_last = 0;
    bit prev_s = 1'b1, prev_rw = 1'b1;
    seed = seed + 3;
    @(negedge clk); sci_mode = sci; start_in = !out_m; start_out = out_m;
    @(negedge clk); start_in = 1'b0; start_out = 1'b0;
    chk(isel == 1'b1, "R10", isel, 1, "isel before first fall");
    @(negedge clk);
    chk(isel == 1'b0 && strobe_n == 1'b0, "R10", isel, 0, "isel low with first strobe");
    while (!isel && t < 5000) begin
      if (poke && t == 100) begin
        mdc_load = 1'b1; mdc_val = 4'd3; start_in = 1'b1; start_out = 1'b1;
      end else if (poke && t == 101) begin
        mdc_load = 1'b0; start_in = 1'b0; start_out = 1'b0;
      end else if (poke && t == 150) begin
        start_in = out_m; start_out = !out_m;
      end else if (poke && t == 151) begin
        start_in = 1'b0; start_out = 1'b0;
      end
      if (prev_s && !strobe_n) begin
        if (last_fall >= 0 && t - last_fall != period) bad_per++;
        if (int'(dig_addr) != first + n_fall) bad_addr++;
        last_fall = t; n_fall++; low_len = 0;
      end
      if (!strobe_n) low_len++;
      if (!prev_s && strobe_n) begin
        if (low_len != 4) bad_wid++;
        rise_t = t;
        if (out_m && dout != xval(dig_addr, seed)) bad_dout++;
      end
      if (!out_m && dout != 4'd0) bad_dout++;
      if (wr_en) begin
        n_wr++;
        if (t - rise_t != 4 || wr_pos != dig_addr || wr_data != dval(dig_addr, seed)) bad_wr++;
      end
      if (prev_rw && !rw_n) begin
        n_rw++; rw_len = 0;
        if (t - rise_t != 4) bad_rw++;
      end
      if (!rw_n) rw_len++;
      if (!prev_rw && rw_n && rw_len != 4) bad_rw++;
      if (done) begin n_done++; done_last = 1; end else done_last = 0;
      prev_s = strobe_n; prev_rw = rw_n; t++;
      @(negedge clk);
    end
    chk(n_fall == slots, "R3", n_fall, slots, "slot count");
    chk(bad_addr == 0, "R9", bad_addr, 0, "position sequence errors");
    chk(bad_per == 0, out_m ? "R6" : "R4", bad_per, 0, "strobe period errors");
    chk(bad_wid == 0, out_m ? "R6" : "R4", bad_wid, 0, "strobe width errors");
    chk(n_wr == (out_m ? 0 : slots), "R5", n_wr, out_m ? 0 : slots, "sample count");
    chk(bad_wr == 0, "R5", bad_wr, 0, "sample timing/data errors");
    chk(n_rw == (out_m ? slots : 0), "R8", n_rw, out_m ? slots : 0, "rw pulse count");
    chk(bad_rw == 0, "R8", bad_rw, 0, "rw pulse errors");
    chk(bad_dout == 0, "R7", bad_dout, 0, "dout errors");
    chk(n_done == 1 && done_last == 1, "R10", n_done, 1, "done pulses in last isel-low clock");
    chk(isel && dig_addr == 4'd0 && dout == 4'd0 && !done, "R9", dig_addr, 0, "idle outputs after burst");
    repeat (3) @(negedge clk);
    chk(isel == 1'b1, "R11", isel, 1, "no restart from mid-burst start");
  endtask

  task automatic t_reset;
    chk(isel && strobe_n && rw_n, "R1", {isel, strobe_n, rw_n}, 7, "idle lines after reset");
    chk(dig_addr == 0 && dout == 0 && !wr_en && wr_data == 0 && wr_pos == 0 && !done,
        "R1", dig_addr, 0, "zero outputs after reset");
  endtask

  task automatic t_default_count;
    run_burst(1'b0, 1'b1, 8, 1'b0);          // R1 default count of 8
  endtask

  task automatic t_short_bursts;
    load_mdc(1);                              // R2
    run_burst(1'b0, 1'b0, 1, 1'b0);
    run_burst(1'b1, 1'b1, 1, 1'b0);
  endtask

  task automatic t_illegal_loads;
    load_mdc(0);                              // R2 ignored
    load_mdc(9);                              // R2 ignored
    run_burst(1'b1, 1'b0, 1, 1'b0);
  endtask

  task automatic t_busy_pokes;
    load_mdc(8);
    run_burst(1'b1, 1'b1, 8, 1'b1);           // R11 starts and R2 load while busy
    run_burst(1'b1, 1'b0, 8, 1'b0);
  endtask

  task automatic t_both_starts;
    @(negedge clk); start_in = 1'b1; start_out = 1'b1;
    @(negedge clk); start_in = 1'b0; start_out = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(isel && strobe_n, "R11", isel, 1, "both starts start nothing");
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_default_count();
    t_short_bursts();
    t_illegal_loads();
    t_busy_pokes();
    t_both_starts();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule